// File: doc/BRIEF.md
# Late-Result Hazard Interlock

This unit sits beside the decode stage of a six-stage in-order pipeline (fetch, decode, execute, memory, align, writeback). Each cycle it receives the decoded register fields and operation class of the instruction in decode. It keeps a small record of the destination register, the late-result flag and the flushing flag for the instructions in the execute and memory stages. From that record it works out whether the decode instruction must wait for a result that cannot be forwarded yet.

Some operations produce their results late. A consumer of such a result needs two cycles between itself and its producer. When a consumer comes too early, the unit raises a decode stall, and each stall cycle injects a bubble into execute.

A flushing operation resolves when it reaches the memory stage. At that point the unit kills the three younger instructions in fetch, decode and execute. While that flush is active, any decode stall is suppressed.

An external bus-busy input freezes every stage this unit tracks. During the freeze the unit holds all of its state and withholds kills.

Top module: `hz_interlock`

## Requirements
- R1: After reset `stall_o`, `kill_o`, `e_vld_o` and `m_vld_o` are all 0, and `advance_o` is 1 while `bus_busy` is low.
- R2: A decode instruction that reads the destination of a late-result operation issued in the slot just before it sees exactly 2 stall cycles. During each stall cycle a bubble enters execute.
- R3: The stall lasts 1 cycle when exactly one slot lies between producer and consumer, and 0 cycles when two or more slots lie between them.
- R4: A producer of class ALU (code 0) never causes a stall. A register field whose enable input is low never matches.
- R5: A late-result operation whose destination is register 0 never causes a stall.
- R6: Class codes 1 (load), 2 (shift/rotate), 3 (control-register read) and 6 (multi-cycle custom) are always late. Codes 4 (multiply) and 5 (divide) are late only when parameter `HW_MULDIV` is 1; with 0 they cause no stall.
- R7: Class code 7 marks a flushing operation. When it sits valid in memory and `advance_o` is 1, `kill_o` is 3'b111 (bit 0 fetch, bit 1 decode, bit 2 execute) for that one cycle. In the next cycle `e_vld_o` and `m_vld_o` are 0, so a killed producer causes no later stall.
- R8: While a flushing operation is valid in memory, `stall_o` is 0 even if a late-result hazard exists.
- R9: While `bus_busy` is 1, `advance_o` is 0, `kill_o` is 0, the tracked stage state is held, and those cycles do not count as stall cycles of the decode instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_valid | input | 1 | Decode slot holds an instruction |
| d_cls | input | 3 | Operation class code of the decode instruction |
| d_rd | input | 5 | Destination register of the decode instruction |
| d_rs1 | input | 5 | First source register |
| d_rs1_en | input | 1 | First source is read |
| d_rs2 | input | 5 | Second source register |
| d_rs2_en | input | 1 | Second source is read |
| bus_busy | input | 1 | External transfer in progress; freezes the pipeline |
| stall_o | output | 1 | Hold decode and inject a bubble |
| advance_o | output | 1 | Stages at and below decode may move this cycle |
| kill_o | output | 3 | Cancel the fetch, decode and execute instructions |
| e_vld_o | output | 1 | Execute stage holds a live instruction |
| m_vld_o | output | 1 | Memory stage holds a live instruction |

## Verification
Three functions can land in the same cycle: the late-result stall, the flush kill and the bus freeze.

The bench provokes stall and flush together by placing a late producer right behind a flushing operation, then a dependent consumer right behind that. It also places a late producer, then a flushing operation, then a consumer, so that a stall cycle comes before the flush resolves. It drives a freeze while a flush waits in memory.

A reference scoreboard steps a two-slot model of execute and memory to predict the stall count for each decode instruction. The bench checks that the stall is dropped in the kill cycle, that the kill is withheld until the freeze ends, and that both tracked stages are empty afterwards.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_W = 5;

    typedef enum logic [2:0] {
        CLS_ALU   = 3'd0,
        CLS_LOAD  = 3'd1,
        CLS_SHIFT = 3'd2,
        CLS_RDCTL = 3'd3,
        CLS_MUL   = 3'd4,
        CLS_DIV   = 3'd5,
        CLS_MCUST = 3'd6,
        CLS_FLUSH = 3'd7
    } op_cls_e;

    typedef struct packed {
        logic             vld;
        logic             late;
        logic             flush;
        logic [REG_W-1:0] rd;
    } slot_t;

    // Late producers need two slots of separation from their consumers.
    function automatic logic cls_is_late(op_cls_e c, logic hw_muldiv);
        case (c)
            CLS_LOAD, CLS_SHIFT, CLS_RDCTL, CLS_MCUST: cls_is_late = 1'b1;
            CLS_MUL, CLS_DIV:                          cls_is_late = hw_muldiv;
            default:                                   cls_is_late = 1'b0;
        endcase
    endfunction

    function automatic logic cls_is_flush(op_cls_e c);
        cls_is_flush = (c == CLS_FLUSH);
    endfunction

    function automatic slot_t build_slot(op_cls_e c, logic [REG_W-1:0] rd, logic hw_muldiv);
        slot_t s;
        s.vld   = 1'b1;
        s.late  = cls_is_late(c, hw_muldiv);
        s.flush = cls_is_flush(c);
        s.rd    = rd;
        return s;
    endfunction

endpackage

// File: rtl/hz_track.sv
module hz_track
    import hz_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    advance,
    input  logic                    push,
    input  slot_t                   push_slot,
    input  logic                    kill_all,
    output slot_t [DEPTH-1:0]       stg
);

    // Entry 0 is execute; entry DEPTH-1 is the stage where flushes resolve.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg[0] <= '0;
        end else if (advance) begin
            stg[0] <= (push && !kill_all) ? push_slot : '0;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[i] <= '0;
            end else if (advance) begin
                stg[i] <= kill_all ? '0 : stg[i-1];
            end
        end
    end

endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  slot_t [DEPTH-1:0]  stg,
    input  logic               d_valid,
    input  logic [REG_W-1:0]   rs1,
    input  logic               rs1_en,
    input  logic [REG_W-1:0]   rs2,
    input  logic               rs2_en,
    output logic               hazard
);

    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic live_dst;
        assign live_dst = stg[i].vld && stg[i].late && (stg[i].rd != '0);
        assign hit[i]   = live_dst &&
                          ((rs1_en && (rs1 == stg[i].rd)) ||
                           (rs2_en && (rs2 == stg[i].rd)));
    end

    assign hazard = d_valid && (|hit);

endmodule

// File: rtl/hz_flush.sv
module hz_flush
    import hz_pkg::*;
#(
    parameter int KILL_W = 3
) (
    input  slot_t              resolve_slot,
    input  logic               advance,
    output logic               flush_active,
    output logic [KILL_W-1:0]  kill
);

    assign flush_active = resolve_slot.vld && resolve_slot.flush;
    assign kill         = (flush_active && advance) ? '1 : '0;

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter bit HW_MULDIV = 1'b1,
    parameter int LATE_GAP  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_valid,
    input  logic [2:0]        d_cls,
    input  logic [REG_W-1:0]  d_rd,
    input  logic [REG_W-1:0]  d_rs1,
    input  logic              d_rs1_en,
    input  logic [REG_W-1:0]  d_rs2,
    input  logic              d_rs2_en,
    input  logic              bus_busy,
    output logic              stall_o,
    output logic              advance_o,
    output logic [LATE_GAP:0] kill_o,
    output logic              e_vld_o,
    output logic              m_vld_o
);

    localparam int KILL_W = LATE_GAP + 1;
    localparam int LAST   = LATE_GAP - 1;

    slot_t [LATE_GAP-1:0] stg;
    slot_t                d_slot;
    logic                 hazard;
    logic                 flush_active;

    assign d_slot    = build_slot(op_cls_e'(d_cls), d_rd, HW_MULDIV);
    assign advance_o = !bus_busy;
    assign stall_o   = hazard && !flush_active;

    hz_track #(.DEPTH(LATE_GAP)) u_track (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance_o),
        .push      (d_valid && !stall_o),
        .push_slot (d_slot),
        .kill_all  (flush_active),
        .stg       (stg)
    );

    hz_detect #(.DEPTH(LATE_GAP)) u_detect (
        .stg     (stg),
        .d_valid (d_valid),
        .rs1     (d_rs1),
        .rs1_en  (d_rs1_en),
        .rs2     (d_rs2),
        .rs2_en  (d_rs2_en),
        .hazard  (hazard)
    );

    hz_flush #(.KILL_W(KILL_W)) u_flush (
        .resolve_slot (stg[LAST]),
        .advance      (advance_o),
        .flush_active (flush_active),
        .kill         (kill_o)
    );

    assign e_vld_o = stg[0].vld;
    assign m_vld_o = stg[LAST].vld;

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
    parameter int KILL_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              stall_o,
    input logic              advance_o,
    input logic [KILL_W-1:0] kill_o,
    input logic              e_vld_o,
    input logic              m_vld_o
);

    // R2: a stall that moves the pipeline leaves a bubble in execute
    a_r2_stall_bubble: assert property (@(posedge clk) disable iff (rst)
        (stall_o && advance_o) |=> !e_vld_o);

    // R7: kills cover every younger stage at once or none
    a_r7_kill_all_or_none: assert property (@(posedge clk) disable iff (rst)
        (kill_o == '0) || (kill_o == '1));

    // R7: after a kill both tracked stages are empty
    a_r7_kill_clears: assert property (@(posedge clk) disable iff (rst)
        (kill_o != '0) |=> (!e_vld_o && !m_vld_o));

    // R8: decode is never stalled while it is being killed
    a_r8_flush_beats_stall: assert property (@(posedge clk) disable iff (rst)
        kill_o[1] |-> !stall_o);

    // R9: a frozen pipeline keeps its state
    a_r9_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        !advance_o |=> ($stable(e_vld_o) && $stable(m_vld_o)));

    // R9: no kill is issued during a freeze
    a_r9_no_kill_frozen: assert property (@(posedge clk) disable iff (rst)
        !advance_o |-> (kill_o == '0));

endmodule

bind hz_interlock hz_interlock_chk #(.KILL_W(LATE_GAP + 1)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall_o   (stall_o),
    .advance_o (advance_o),
    .kill_o    (kill_o),
    .e_vld_o   (e_vld_o),
    .m_vld_o   (m_vld_o)
);

// File: tb/sim_hz_interlock.sv
`timescale 1ns/1ps
module sim_hz_interlock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       d_valid = 1'b0;
    logic [2:0] d_cls = 3'd0;
    logic [4:0] d_rd = 5'd0, d_rs1 = 5'd0, d_rs2 = 5'd0;
    logic       d_rs1_en = 1'b0, d_rs2_en = 1'b0;
    logic       bus_busy = 1'b0;
    logic       stall_o, advance_o, e_vld_o, m_vld_o;
    logic [2:0] kill_o;
    logic       s1_stall, s1_adv, s1_ev, s1_mv;
    logic [2:0] s1_kill;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hz_interlock u0 (
        .clk(clk), .rst(rst), .d_valid(d_valid), .d_cls(d_cls), .d_rd(d_rd),
        .d_rs1(d_rs1), .d_rs1_en(d_rs1_en), .d_rs2(d_rs2), .d_rs2_en(d_rs2_en),
        .bus_busy(bus_busy), .stall_o(stall_o), .advance_o(advance_o),
        .kill_o(kill_o), .e_vld_o(e_vld_o), .m_vld_o(m_vld_o)
    );

    hz_interlock #(.HW_MULDIV(1'b0)) u1 (
        .clk(clk), .rst(rst), .d_valid(d_valid), .d_cls(d_cls), .d_rd(d_rd),
        .d_rs1(d_rs1), .d_rs1_en(d_rs1_en), .d_rs2(d_rs2), .d_rs2_en(d_rs2_en),
        .bus_busy(bus_busy), .stall_o(s1_stall), .advance_o(s1_adv),
        .kill_o(s1_kill), .e_vld_o(s1_ev), .m_vld_o(s1_mv)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: slot 0 = execute, slot 1 = memory
    bit       hv[2], hl[2], hf[2];
    int       hr[2];
    int       exp_q[$];
    string    req_q[$];

    function automatic bit ref_late(int c);
        return (c == 1) || (c == 2) || (c == 3) || (c == 6) || (c == 4) || (c == 5);
    endfunction

    function automatic void ref_shift(bit v, bit l, bit f, int rd);
        if (hv[1] && hf[1]) begin
            hv[0] = 0; hv[1] = 0; hl[0] = 0; hl[1] = 0; hf[0] = 0; hf[1] = 0;
        end else begin
            hv[1] = hv[0]; hl[1] = hl[0]; hf[1] = hf[0]; hr[1] = hr[0];
            hv[0] = v; hl[0] = l; hf[0] = f; hr[0] = rd;
        end
    endfunction

    task automatic issue(input int cls, input int rd, input int rs1, input bit e1,
                         input int rs2, input bit e2, input int nfz,
                         input bit chk_u1, input string req);
        int  ex = 0;
        bit  fl = 0;
        bit  ev0;
        forever begin
            bit hit = 0;
            if (hv[1] && hf[1]) begin fl = 1; break; end
            for (int i = 0; i < 2; i++)
                if (hv[i] && hl[i] && hr[i] != 0 &&
                    ((e1 && rs1 == hr[i]) || (e2 && rs2 == hr[i]))) hit = 1;
            if (!hit) break;
            ex++;
            ref_shift(0, 0, 0, 0);
        end
        ref_shift(1, ref_late(cls), cls == 7, rd);
        exp_q.push_back(ex);
        req_q.push_back(req);

        @(negedge clk);
        d_valid = 1; d_cls = cls[2:0]; d_rd = rd[4:0];
        d_rs1 = rs1[4:0]; d_rs1_en = e1; d_rs2 = rs2[4:0]; d_rs2_en = e2;
        bus_busy = (nfz > 0);
        if (chk_u1) begin
            #1;
            check(s1_stall == 1'b0, "R6 no stall without hw muldiv", s1_stall, 0);
        end
        for (int k = 0; k < nfz; k++) begin
            #1;
            if (k == 0) ev0 = e_vld_o;
            check(advance_o == 1'b0, "R9 advance low", advance_o, 0);
            check(kill_o == 3'b000, "R9 kill withheld", kill_o, 0);
            check(e_vld_o == ev0, "R9 state held", e_vld_o, ev0);
            @(negedge clk);
        end
        bus_busy = 0;
        #1;
        while (stall_o) begin
            @(negedge clk);
            #1;
        end
        if (fl) begin
            check(kill_o == 3'b111, "R7 kill all younger", kill_o, 7);
            check(stall_o == 1'b0, "R8 stall suppressed", stall_o, 0);
            @(posedge clk);
            #1;
            check(e_vld_o == 1'b0 && m_vld_o == 1'b0, "R7 stages emptied",
                  {e_vld_o, m_vld_o}, 0);
        end
    endtask

    task automatic bubble();
        @(negedge clk);
        d_valid = 0; d_rs1_en = 0; d_rs2_en = 0;
        ref_shift(0, 0, 0, 0);
    endtask

    // Monitor: counts stall cycles per decode instruction and compares
    int scnt = 0;
    always @(negedge clk) begin
        #2;
        if (!rst && d_valid && advance_o) begin
            if (stall_o) scnt++;
            else if (exp_q.size() != 0) begin
                int e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(scnt == e, r, scnt, e);
                scnt = 0;
            end
        end
    end

    initial begin
        #2_000_000;
        check(1'b0, "watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin hv[i] = 0; hl[i] = 0; hf[i] = 0; hr[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(stall_o == 0, "R1 stall after reset", stall_o, 0);
        check(kill_o == 0, "R1 kill after reset", kill_o, 0);
        check(e_vld_o == 0 && m_vld_o == 0, "R1 valids after reset", {e_vld_o, m_vld_o}, 0);
        check(advance_o == 1, "R1 advance after reset", advance_o, 1);

        issue(4, 3, 0, 0, 0, 0, 0, 0, "R6 multiply producer");
        issue(0, 1, 3, 1, 0, 0, 0, 1, "R6 multiply consumer");
        bubble(); bubble();
        issue(1, 5, 0, 0, 0, 0, 0, 0, "R2 load");
        issue(0, 1, 5, 1, 0, 0, 0, 0, "R2 back-to-back consumer");
        issue(2, 6, 0, 0, 0, 0, 0, 0, "R3 shift");
        issue(0, 7, 0, 0, 0, 0, 0, 0, "R3 filler");
        issue(0, 1, 0, 0, 6, 1, 0, 0, "R3 one-apart consumer");
        issue(3, 8, 0, 0, 0, 0, 0, 0, "R3 ctl read");
        issue(0, 9, 0, 0, 0, 0, 0, 0, "R3 filler");
        issue(0, 2, 0, 0, 0, 0, 0, 0, "R3 filler");
        issue(0, 1, 8, 1, 0, 0, 0, 0, "R3 two-apart consumer");
        issue(0, 9, 0, 0, 0, 0, 0, 0, "R4 alu producer");
        issue(0, 1, 9, 1, 9, 1, 0, 0, "R4 alu consumer");
        issue(1, 10, 0, 0, 0, 0, 0, 0, "R4 load");
        issue(0, 1, 10, 0, 10, 0, 0, 0, "R4 disabled sources");
        issue(1, 0, 0, 0, 0, 0, 0, 0, "R5 load to r0");
        issue(0, 1, 0, 1, 0, 1, 0, 0, "R5 r0 consumer");
        issue(6, 11, 0, 0, 0, 0, 0, 0, "R6 custom");
        issue(0, 1, 11, 1, 11, 1, 0, 0, "R6 custom consumer");
        issue(5, 12, 0, 0, 0, 0, 0, 0, "R6 divide");
        issue(0, 1, 0, 0, 12, 1, 0, 0, "R6 divide consumer");
        bubble(); bubble();
        issue(7, 0, 0, 0, 0, 0, 0, 0, "R8 flush op");
        issue(1, 13, 0, 0, 0, 0, 0, 0, "R8 load behind flush");
        issue(0, 1, 13, 1, 0, 0, 0, 0, "R8 consumer during flush");
        issue(0, 1, 13, 1, 0, 0, 0, 0, "R7 consumer of killed load");
        bubble(); bubble();
        issue(1, 14, 0, 0, 0, 0, 0, 0, "R8 load before flush");
        issue(7, 0, 0, 0, 0, 0, 0, 0, "R8 flush op");
        issue(0, 1, 14, 1, 0, 0, 0, 0, "R8 stall then flush");
        bubble(); bubble();
        issue(1, 15, 0, 0, 0, 0, 0, 0, "R9 load");
        issue(0, 1, 15, 1, 0, 0, 3, 0, "R9 frozen consumer");
        bubble(); bubble();
        issue(7, 0, 0, 0, 0, 0, 0, 0, "R9 flush op");
        issue(0, 4, 0, 0, 0, 0, 0, 0, "R9 filler");
        issue(0, 1, 0, 0, 0, 0, 2, 0, "R9 flush held by freeze");
        bubble(); bubble(); bubble();
        #3;
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule